// File: doc/BRIEF.md
# Per-Source Steerable Interrupt Controller

This block collects 32 interrupt request lines from the rest of the chip and turns them into two processor request outputs: a normal request and a fast request. Each line has its own sensitivity setting. It can be level-sensitive or edge-triggered, and it can be active-high or active-low. Every line is first brought into the controller's clock domain, then interpreted according to its settings and recorded in a pending register.

Software uses a small synchronous register port to do three things. It enables lines, picks which of the two outputs each line drives, and acknowledges latched edges by writing ones to the pending register. Both outputs are plain levels derived from registered state. A second instance of the controller can therefore feed one source line of a first instance.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset, the enable (offset 0x00), polarity (0x0C), sensitivity (0x10) and steering (0x14) registers all read as zero, and both request outputs are low.
- R2: Every source line passes through two synchroniser flops. A source change driven before clock edge k shows in the pending register after edge k+2.
- R3: In level mode (sensitivity bit 0), a pending bit follows its synchronised line after polarity is applied. A polarity bit of 0 makes a low line active. Writing a 1 to that pending bit (offset 0x04) changes nothing.
- R4: In edge mode (sensitivity bit 1) with polarity bit 1, a rising edge of the synchronised line sets the pending bit. The bit then stays set after the line returns low.
- R5: In edge mode with polarity bit 0, a falling edge of the synchronised line sets the pending bit.
- R6: In edge mode, writing 1 to a pending bit at offset 0x04 clears it. Writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R7: Offset 0x08 reads the pending bits ANDed with the enable bits. A line whose enable bit is 0 never drives an output. Writes to 0x08 have no effect.
- R8: Offsets 0x00, 0x0C, 0x10 and 0x14 read back the last value written. Any other address reads zero, and writes to it have no effect.
- R9: The fast output is the OR of the enabled pending bits whose steering bit is 1. The normal output is the OR of the enabled pending bits whose steering bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Asynchronous interrupt source lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data for addr_i (same cycle) |
| irq_o | output | 1 | Normal request level |
| fiq_o | output | 1 | Fast request level |

## Verification
The hardest case to reach is a pending-bit clear that arrives in the same cycle as a new edge on that line. The new edge must win. To reach it, the stimulus drives the source change and then counts the two synchroniser cycles. It issues the clear write in the cycle where the edge reaches detection. A falling-edge line is another awkward case, because changing its polarity can itself create a false edge. That line is set up in level mode first and switched to edge mode once the line is stable. A long random phase then mixes source toggles with writes to every register, and a behavioural model checks the outputs against the design on every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned NSRC_DEFAULT = 32;
    localparam logic [7:0] OFS_ENABLE = 8'h00;
    localparam logic [7:0] OFS_PEND   = 8'h04;
    localparam logic [7:0] OFS_STATUS = 8'h08;
    localparam logic [7:0] OFS_POL    = 8'h0C;
    localparam logic [7:0] OFS_SENSE  = 8'h10;
    localparam logic [7:0] OFS_STEER  = 8'h14;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] st_d [STAGES];
    logic [WIDTH-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= st_d[i];
        end
    end

    assign sync_o = st_q[STAGES-1];
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] sync_i,
    input  logic [WIDTH-1:0] pol_i,
    input  logic [WIDTH-1:0] edge_mode_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] pend_o
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] pend;
    } pend_state_t;

    pend_state_t s_d, s_q;
    logic [WIDTH-1:0] act;
    logic [WIDTH-1:0] hit;

    always_comb begin
        act  = ~(sync_i ^ pol_i);
        hit  = act & ~s_q.prev;
        s_d.prev = act;
        s_d.pend = (edge_mode_i & ((s_q.pend & ~clr_i) | hit))
                 | (~edge_mode_i & act);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign pend_o = s_q.pend;

    a_r3_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((s_q.pend & ~$past(edge_mode_i)) == ($past(act) & ~$past(edge_mode_i))));

    a_r4_edge_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((s_q.pend & $past(s_q.pend & edge_mode_i & ~clr_i))
                           == $past(s_q.pend & edge_mode_i & ~clr_i)));

    a_r6_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((s_q.pend & $past(clr_i & edge_mode_i & ~hit)) == '0));
endmodule

// File: rtl/irqc_route.sv
module irqc_route #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] active_i,
    input  logic [WIDTH-1:0] steer_i,
    output logic             fast_o,
    output logic             norm_o
);
    assign fast_o = |(active_i & steer_i);
    assign norm_o = |(active_i & ~steer_i);
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl #(
    parameter int N_SRC       = irqc_pkg::NSRC_DEFAULT,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_SRC-1:0]  src_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N_SRC-1:0]  wdata_i,
    output logic [N_SRC-1:0]  rdata_o,
    output logic              irq_o,
    output logic              fiq_o
);
    import irqc_pkg::*;

    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_PND = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_POL = ADDR_W'(OFS_POL);
    localparam logic [ADDR_W-1:0] A_SEN = ADDR_W'(OFS_SENSE);
    localparam logic [ADDR_W-1:0] A_STR = ADDR_W'(OFS_STEER);

    typedef struct packed {
        logic [N_SRC-1:0] enable;
        logic [N_SRC-1:0] pol;
        logic [N_SRC-1:0] sense;
        logic [N_SRC-1:0] steer;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic [N_SRC-1:0] synced;
    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] clr;
    logic [N_SRC-1:0] active;

    always_comb begin
        c_d = c_q;
        clr = '0;
        if (wr_en_i) begin
            if (addr_i == A_EN)  c_d.enable = wdata_i;
            if (addr_i == A_POL) c_d.pol    = wdata_i;
            if (addr_i == A_SEN) c_d.sense  = wdata_i;
            if (addr_i == A_STR) c_d.steer  = wdata_i;
            if (addr_i == A_PND) clr        = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) c_q <= '0;
        else         c_q <= c_d;
    end

    irqc_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (src_i),
        .sync_o  (synced)
    );

    irqc_pend #(.WIDTH(N_SRC)) u_pend (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sync_i      (synced),
        .pol_i       (c_q.pol),
        .edge_mode_i (c_q.sense),
        .clr_i       (clr),
        .pend_o      (pend)
    );

    assign active = pend & c_q.enable;

    irqc_route #(.WIDTH(N_SRC)) u_route (
        .active_i (active),
        .steer_i  (c_q.steer),
        .fast_o   (fiq_o),
        .norm_o   (irq_o)
    );

    always_comb begin
        if      (addr_i == A_EN)  rdata_o = c_q.enable;
        else if (addr_i == A_PND) rdata_o = pend;
        else if (addr_i == A_ST)  rdata_o = active;
        else if (addr_i == A_POL) rdata_o = c_q.pol;
        else if (addr_i == A_SEN) rdata_o = c_q.sense;
        else if (addr_i == A_STR) rdata_o = c_q.steer;
        else                      rdata_o = '0;
    end

    a_r7_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_q.enable == '0) |-> !(irq_o || fiq_o));

    a_r9_fast_needs_steer: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fiq_o |-> ((c_q.steer & c_q.enable) != '0));

    a_r9_norm_needs_unsteered: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((~c_q.steer & c_q.enable) != '0));
endmodule

// File: tb/irq_steer_ctrl_tb.sv
module irq_steer_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    irq_steer_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_en_i(wr_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
    );

    // behavioural reference
    logic [31:0] m_en, m_pol, m_sen, m_str, m_pnd, m_prev;
    logic [31:0] hist[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en = '0; m_pol = '0; m_sen = '0; m_str = '0; m_pnd = '0; m_prev = '0;
            hist.delete();
        end else begin
            logic [31:0] s, act, hit, clrv;
            s = (hist.size() >= 2) ? hist[hist.size()-2] : '0;
            hist.push_back(src);
            if (hist.size() > 4) void'(hist.pop_front());
            act  = ~(s ^ m_pol);
            hit  = act & ~m_prev;
            clrv = (wr_en && addr == 5'h04) ? wdata : '0;
            for (int i = 0; i < 32; i++) begin
                if (m_sen[i]) m_pnd[i] = (m_pnd[i] && !clrv[i]) || hit[i];
                else          m_pnd[i] = act[i];
            end
            m_prev = act;
            if (wr_en) begin
                case (addr)
                    5'h00: m_en  = wdata;
                    5'h0C: m_pol = wdata;
                    5'h10: m_sen = wdata;
                    5'h14: m_str = wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return m_en;
            5'h04: return m_pnd;
            5'h08: return m_pnd & m_en;
            5'h0C: return m_pol;
            5'h10: return m_sen;
            5'h14: return m_str;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act_v, exp_v, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (rst_n && !finished) begin
            logic [31:0] a;
            a = m_read(addr);
            chk("R9 fiq", {31'b0, fiq}, {31'b0, |(m_pnd & m_en & m_str)});
            chk("R9 irq", {31'b0, irq}, {31'b0, |(m_pnd & m_en & ~m_str)});
            chk("R8 rdata", rdata, a);
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_at(input logic [4:0] a);
        @(negedge clk);
        addr = a;
        #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset values
        rd_at(5'h00); chk("R1 enable", rdata, 32'h0);
        rd_at(5'h0C); chk("R1 pol", rdata, 32'h0);
        rd_at(5'h10); chk("R1 sense", rdata, 32'h0);
        rd_at(5'h14); chk("R1 steer", rdata, 32'h0);
        chk("R1 outputs", {30'b0, irq, fiq}, 32'h0);

        // R3 active-low level with idle lines: all pending, write-1 ignored
        idle(4);
        rd_at(5'h04); chk("R3 level low", rdata, 32'hFFFF_FFFF);
        wr(5'h04, 32'hFFFF_FFFF);
        rd_at(5'h04); chk("R3 w1 ignored", rdata, 32'hFFFF_FFFF);
        wr(5'h0C, 32'hFFFF_FFFF);
        idle(2);
        rd_at(5'h04); chk("R3 level high", rdata, 32'h0);

        // R2 synchroniser latency
        wr(5'h00, 32'h0000_0031);
        @(negedge clk); src[0] = 1'b1;
        @(negedge clk); #2 chk("R2 edge1", {31'b0, irq}, 32'h0);
        @(negedge clk); #2 chk("R2 edge2", {31'b0, irq}, 32'h0);
        @(negedge clk); #2 chk("R2 edge3", {31'b0, irq}, 32'h1);

        // R9 steering
        wr(5'h14, 32'h0000_0001);
        #2;
        chk("R9 steer fiq", {30'b0, irq, fiq}, 32'h1);
        @(negedge clk); src[0] = 1'b0;
        idle(4);

        // R4 rising edge latch on line 4
        wr(5'h10, 32'h0000_0010);
        @(negedge clk); src[4] = 1'b1;
        @(negedge clk); src[4] = 1'b0;
        idle(5);
        rd_at(5'h04); chk("R4 latched", {31'b0, rdata[4]}, 32'h1);
        chk("R4 irq", {31'b0, irq}, 32'h1);

        // R6 clear, write-0 no effect
        wr(5'h04, 32'h0);
        rd_at(5'h04); chk("R6 w0 keeps", {31'b0, rdata[4]}, 32'h1);
        wr(5'h04, 32'h0000_0010);
        rd_at(5'h04); chk("R6 w1 clears", {31'b0, rdata[4]}, 32'h0);

        // R6 clear coinciding with new edge
        @(negedge clk); src[4] = 1'b1;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 5'h04; wdata = 32'h0000_0010;
        @(negedge clk); wr_en = 1'b0;
        #2 chk("R6 edge wins", {31'b0, rdata[4]}, 32'h1);
        @(negedge clk); src[4] = 1'b0;

        // R5 falling edge on line 5
        @(negedge clk); src[5] = 1'b1;
        idle(4);
        wr(5'h0C, 32'hFFFF_FFDF);
        idle(2);
        wr(5'h10, 32'h0000_0030);
        idle(2);
        rd_at(5'h04); chk("R5 idle", {31'b0, rdata[5]}, 32'h0);
        @(negedge clk); src[5] = 1'b0;
        @(negedge clk); src[5] = 1'b1;
        idle(5);
        rd_at(5'h04); chk("R5 falling latched", {31'b0, rdata[5]}, 32'h1);

        // R7 status and ignored writes, R8 unused address
        rd_at(5'h08); chk("R7 status", rdata, m_pnd & m_en);
        wr(5'h08, 32'h0);
        rd_at(5'h08); chk("R7 status write ignored", rdata, m_pnd & m_en);
        wr(5'h00, 32'h0);
        rd_at(5'h08); chk("R7 masked status", rdata, 32'h0);
        chk("R7 masked outputs", {30'b0, irq, fiq}, 32'h0);
        wr(5'h18, 32'hFFFF_FFFF);
        rd_at(5'h18); chk("R8 unused reads zero", rdata, 32'h0);
        rd_at(5'h14); chk("R8 steer unchanged", rdata, 32'h1);

        // random mix
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            src = src ^ ($urandom() & $urandom() & $urandom());
            if ($urandom_range(0, 3) == 0) begin
                logic [2:0] sel;
                sel = 3'($urandom_range(0, 6));
                wr_en = 1'b1;
                addr = (sel == 3'd6) ? 5'h1C : {sel, 2'b00};
                wdata = $urandom();
            end else begin
                wr_en = 1'b0;
                addr = {3'($urandom_range(0, 5)), 2'b00};
            end
        end
        @(negedge clk); wr_en = 1'b0;
        idle(2);
        finish_run();
    end
endmodule